// File: doc/BRIEF.md
# Statistical Direction Corrector

This block sits behind a tagged main branch predictor and second-guesses it. The main predictor reports a small signed confidence counter, whose sign is its direction. The corrector reads one 6-bit signed counter from each of five logical tables. Each table is indexed by a hash of the branch address, a slice of global history of its own length, and the main predictor's direction. All five logical tables live in one physical counter array, banked by interleaving.

The centered counter values are added to eight times the main predictor's centered confidence. The main direction is inverted only when the sum points the other way and its magnitude clears a threshold that tunes itself at run time.

At branch resolution the block recomputes the same sum from the update-side inputs. It trains the counters toward the real outcome and adapts the threshold, depending on whether inverting would have helped. Producing the main prediction and keeping the global history are left to the surrounding predictor.

Top module: `stat_corrector`

## Requirements
- R1: Table t (0..4) uses history length 0, 3, 8, 12 or 17 bits respectively. Its logical index is {main direction, h}, where h has IDX_W-1 bits. Bit j of h is the XOR of every address bit i and every used history bit i with i mod (IDX_W-1) = j. The physical entry is that index with its low two bits XORed with t mod 4.
- R2: After reset every counter is 0, the threshold equals THR_INIT and the adaptation counter is 0.
- R3: The sum is the total over the five tables of (2c+1) plus 8*(2m+1). Here c is a table counter and m is the signed main confidence; the main direction is taken when m >= 0.
- R4: pred_flip is 1 exactly when the sum's direction (taken when sum >= 0) differs from the main direction and |sum| > threshold. pred_dir is then the sum's direction; otherwise it is the main direction.
- R5: On an update where the recomputed final direction differs from upd_taken, or where |sum| <= threshold, each of the five addressed counters moves one step toward the outcome. Counters saturate at -32 and +31.
- R6: On an update where the sum's direction differs from the main direction, the adaptation counter goes up if the sum's direction was wrong and down if it was right. Moving up from its maximum raises the threshold by one; moving down from its minimum lowers it by one. In both cases the adaptation counter returns to 0.
- R7: The threshold stays within 0 .. 2^THR_W-1 and does not wrap.
- R8: While upd_valid is 0, no counter, threshold or adaptation state changes.
- R9: The prediction is combinational from the current state; an update is visible to predictions from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | Branch address being predicted |
| pred_hist | input | HIST_W | Global history, bit 0 most recent |
| pred_main_ctr | input | MCTR_W | Main predictor's signed confidence |
| pred_dir | output | 1 | Final direction, 1 = taken |
| pred_flip | output | 1 | Main direction was inverted |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | Resolved branch address |
| upd_hist | input | HIST_W | History seen at prediction time |
| upd_main_ctr | input | MCTR_W | Main confidence seen at prediction time |
| upd_taken | input | 1 | Actual outcome |

## Verification
The bench keeps the 10-bit index and 6-bit counters but narrows the threshold to 3 bits and the adaptation counter to 4 bits, with a starting threshold of 4. With these values a few dozen correction attempts are enough to step the threshold, so both threshold limits and the adaptation recentring can be reached in a short run. Many branches are trained until their counters saturate, so inversions actually happen and can be compared cycle by cycle against a behavioural model.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef enum logic [1:0] {
    ADP_HOLD = 2'd0,
    ADP_UP   = 2'd1,
    ADP_DOWN = 2'd2
  } adp_evt_e;

  // History length used by each logical table
  function automatic int sc_hist_len(int t);
    case (t)
      0:       return 0;
      1:       return 3;
      2:       return 8;
      3:       return 12;
      4:       return 17;
      default: return 17 + 5 * (t - 4);
    endcase
  endfunction

  // Centered value of a signed counter: never zero
  function automatic int sc_center(int v);
    return 2 * v + 1;
  endfunction

  // Saturating single step toward the outcome
  function automatic int sc_step(int v, logic up, int lo, int hi);
    if (up) return (v >= hi) ? hi : v + 1;
    return (v <= lo) ? lo : v - 1;
  endfunction

endpackage

// File: rtl/sc_index.sv
module sc_index #(
  parameter int TBL    = 0,
  parameter int PC_W   = 16,
  parameter int HIST_W = 17,
  parameter int IDX_W  = 10
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  input  logic              dir,
  output logic [IDX_W-1:0]  addr
);
  import sc_pkg::*;

  localparam int         HW   = IDX_W - 1;
  localparam int         LEN  = sc_hist_len(TBL);
  localparam logic [1:0] BSEL = 2'(TBL % 4);

  logic [HW-1:0]    hash;
  logic [IDX_W-1:0] lidx;

  always_comb begin
    hash = '0;
    for (int i = 0; i < PC_W; i++)
      hash[i % HW] = hash[i % HW] ^ pc[i];
    for (int i = 0; i < HIST_W; i++)
      if (i < LEN) hash[i % HW] = hash[i % HW] ^ hist[i];
    lidx = {dir, hash};
    addr = {lidx[IDX_W-1:2], lidx[1:0] ^ BSEL};
  end

endmodule

// File: rtl/sc_store.sv
module sc_store #(
  parameter int NUM_TBL = 5,
  parameter int IDX_W   = 10,
  parameter int CTR_W   = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_TBL-1:0][IDX_W-1:0]   addr_p,
  output logic [NUM_TBL-1:0][CTR_W-1:0]   data_p,
  input  logic [NUM_TBL-1:0][IDX_W-1:0]   addr_u,
  output logic [NUM_TBL-1:0][CTR_W-1:0]   data_u,
  input  logic [NUM_TBL-1:0]              wr_en,
  input  logic [NUM_TBL-1:0][CTR_W-1:0]   wr_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [CTR_W-1:0] mem [DEPTH];

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_rd
    assign data_p[t] = mem[addr_p[t]];
    assign data_u[t] = mem[addr_u[t]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int t = 0; t < NUM_TBL; t++)
        if (wr_en[t]) mem[addr_u[t]] <= wr_data[t];
    end
  end

endmodule

// File: rtl/sc_sum.sv
module sc_sum #(
  parameter int NUM_TBL = 5,
  parameter int CTR_W   = 6,
  parameter int MCTR_W  = 3,
  parameter int THR_W   = 6,
  parameter int SUM_W   = 10
) (
  input  logic [NUM_TBL-1:0][CTR_W-1:0] ctrs,
  input  logic [MCTR_W-1:0]             main_ctr,
  input  logic [THR_W-1:0]              thr,
  output logic                          main_dir,
  output logic                          sum_dir,
  output logic                          above,
  output logic                          flip,
  output logic                          final_dir
);
  import sc_pkg::*;

  logic signed [SUM_W-1:0] sum;
  logic        [SUM_W-1:0] mag;

  always_comb begin
    int acc;
    acc = 8 * sc_center(int'($signed(main_ctr)));
    for (int t = 0; t < NUM_TBL; t++)
      acc = acc + sc_center(int'($signed(ctrs[t])));
    sum       = SUM_W'(acc);
    main_dir  = ~main_ctr[MCTR_W-1];
    sum_dir   = ~sum[SUM_W-1];
    mag       = sum_dir ? sum : -sum;
    above     = mag > SUM_W'(thr);
    flip      = (sum_dir != main_dir) && above;
    final_dir = flip ? sum_dir : main_dir;
  end

endmodule

// File: rtl/sc_thresh.sv
module sc_thresh #(
  parameter int THR_W    = 6,
  parameter int ADP_W    = 6,
  parameter int THR_INIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sc_pkg::adp_evt_e evt,
  output logic [THR_W-1:0] thr
);
  import sc_pkg::*;

  localparam logic signed [ADP_W-1:0] A_MAX = {1'b0, {(ADP_W-1){1'b1}}};
  localparam logic signed [ADP_W-1:0] A_MIN = {1'b1, {(ADP_W-1){1'b0}}};
  localparam logic [THR_W-1:0]        T_MAX = '1;

  logic signed [ADP_W-1:0] acnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acnt <= '0;
      thr  <= THR_W'(THR_INIT);
    end else begin
      case (evt)
        ADP_UP: begin
          if (acnt == A_MAX) begin
            acnt <= '0;
            if (thr != T_MAX) thr <= thr + 1'b1;
          end else acnt <= acnt + 1'b1;
        end
        ADP_DOWN: begin
          if (acnt == A_MIN) begin
            acnt <= '0;
            if (thr != '0) thr <= thr - 1'b1;
          end else acnt <= acnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_THR_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(thr) |-> (thr == $past(thr) + 1'b1) || (thr == $past(thr) - 1'b1)); // R6
  AST_ADP_RECENTRE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(thr) |-> acnt == '0); // R6
  AST_THR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(thr) == T_MAX) |-> thr != '0); // R7

endmodule

// File: rtl/stat_corrector.sv
module stat_corrector #(
  parameter int NUM_TBL  = 5,
  parameter int PC_W     = 16,
  parameter int HIST_W   = 17,
  parameter int IDX_W    = 10,
  parameter int CTR_W    = 6,
  parameter int MCTR_W   = 3,
  parameter int THR_W    = 6,
  parameter int ADP_W    = 6,
  parameter int THR_INIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pred_pc,
  input  logic [HIST_W-1:0] pred_hist,
  input  logic [MCTR_W-1:0] pred_main_ctr,
  output logic              pred_dir,
  output logic              pred_flip,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic [MCTR_W-1:0] upd_main_ctr,
  input  logic              upd_taken
);
  import sc_pkg::*;

  localparam int SUM_W  = $clog2(NUM_TBL * (1 << CTR_W) + 8 * (1 << MCTR_W)) + 1;
  localparam int C_LO   = -(1 << (CTR_W - 1));
  localparam int C_HI   = (1 << (CTR_W - 1)) - 1;

  logic [NUM_TBL-1:0][IDX_W-1:0] addr_p, addr_u;
  logic [NUM_TBL-1:0][CTR_W-1:0] rd_p, rd_u, wdata;
  logic [NUM_TBL-1:0]            wen;
  logic [THR_W-1:0]              thr;

  logic p_main_dir, p_sum_dir, p_above, p_flip, p_final;
  logic u_main_dir, u_sum_dir, u_above, u_flip, u_final;
  logic train, attempt, attempt_wrong;
  adp_evt_e evt;

  // Direction bits feeding the table index come from the confidence sign
  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    sc_index #(.TBL(t), .PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_idx_p (
      .pc(pred_pc), .hist(pred_hist), .dir(~pred_main_ctr[MCTR_W-1]), .addr(addr_p[t]));
    sc_index #(.TBL(t), .PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_idx_u (
      .pc(upd_pc), .hist(upd_hist), .dir(~upd_main_ctr[MCTR_W-1]), .addr(addr_u[t]));

    assign wdata[t] = CTR_W'(sc_step(int'($signed(rd_u[t])), upd_taken, C_LO, C_HI));
    assign wen[t]   = train;

    AST_CTR_TOWARD: assert property (@(posedge clk) disable iff (!rst_n)
      wen[t] |-> (upd_taken ? ($signed(wdata[t]) >= $signed(rd_u[t]))
                            : ($signed(wdata[t]) <= $signed(rd_u[t])))
                 && (wdata[t] == rd_u[t] || wdata[t] == rd_u[t] + 1'b1
                     || wdata[t] == rd_u[t] - 1'b1)); // R5
  end

  sc_store #(.NUM_TBL(NUM_TBL), .IDX_W(IDX_W), .CTR_W(CTR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .addr_p(addr_p), .data_p(rd_p),
    .addr_u(addr_u), .data_u(rd_u),
    .wr_en(wen), .wr_data(wdata));

  sc_sum #(.NUM_TBL(NUM_TBL), .CTR_W(CTR_W), .MCTR_W(MCTR_W), .THR_W(THR_W), .SUM_W(SUM_W)) u_sum_p (
    .ctrs(rd_p), .main_ctr(pred_main_ctr), .thr(thr),
    .main_dir(p_main_dir), .sum_dir(p_sum_dir), .above(p_above),
    .flip(p_flip), .final_dir(p_final));

  sc_sum #(.NUM_TBL(NUM_TBL), .CTR_W(CTR_W), .MCTR_W(MCTR_W), .THR_W(THR_W), .SUM_W(SUM_W)) u_sum_u (
    .ctrs(rd_u), .main_ctr(upd_main_ctr), .thr(thr),
    .main_dir(u_main_dir), .sum_dir(u_sum_dir), .above(u_above),
    .flip(u_flip), .final_dir(u_final));

  // Training and adaptation events at resolution
  assign train         = upd_valid && ((u_final != upd_taken) || !u_above);
  assign attempt       = upd_valid && (u_sum_dir != u_main_dir);
  assign attempt_wrong = u_sum_dir != upd_taken;
  assign evt           = !attempt ? ADP_HOLD : (attempt_wrong ? ADP_UP : ADP_DOWN);

  sc_thresh #(.THR_W(THR_W), .ADP_W(ADP_W), .THR_INIT(THR_INIT)) u_thr (
    .clk(clk), .rst_n(rst_n), .evt(evt), .thr(thr));

  assign pred_dir  = p_final;
  assign pred_flip = p_flip;

  AST_FLIP_NEEDS_MARGIN: assert property (@(posedge clk) disable iff (!rst_n)
    pred_flip |-> p_above && (p_sum_dir != p_main_dir)); // R4
  AST_FLIP_AGAINST_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    pred_flip |-> pred_dir == pred_main_ctr[MCTR_W-1]); // R4
  AST_THR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(thr)); // R8
  AST_FLIP_UPD_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    u_flip |-> u_final == u_sum_dir); // R4

endmodule

// File: tb/stat_corrector_bench.sv
module stat_corrector_bench;
  localparam int NT = 5, PCW = 16, HW = 17, IW = 10, CW = 6, MW = 3;
  localparam int TW = 3, AW = 4, TINIT = 4;
  localparam int HASH_MOD = IW - 1;
  localparam int DEPTH = 1 << IW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PCW-1:0] pred_pc = '0, upd_pc = '0;
  logic [HW-1:0]  pred_hist = '0, upd_hist = '0;
  logic [MW-1:0]  pred_main_ctr = '0, upd_main_ctr = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0;
  logic pred_dir, pred_flip;

  always #4 clk = ~clk;

  stat_corrector #(.NUM_TBL(NT), .PC_W(PCW), .HIST_W(HW), .IDX_W(IW), .CTR_W(CW),
                   .MCTR_W(MW), .THR_W(TW), .ADP_W(AW), .THR_INIT(TINIT)) u_stat_corrector (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_hist(pred_hist),
    .pred_main_ctr(pred_main_ctr), .pred_dir(pred_dir), .pred_flip(pred_flip),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist),
    .upd_main_ctr(upd_main_ctr), .upd_taken(upd_taken));

  // Behavioural reference model state
  int m_tab [DEPTH];
  int m_thr = TINIT;
  int m_adp = 0;
  int hl [NT] = '{0, 3, 8, 12, 17};
  int n_checks = 0, n_fails = 0;
  string tag = "R2";

  function automatic int m_addr(int t, int pc, int hist, int dir);
    int h = 0, idx;
    for (int i = 0; i < PCW; i++) if ((pc >> i) & 1) h = h ^ (1 << (i % HASH_MOD));
    for (int i = 0; i < hl[t]; i++) if ((hist >> i) & 1) h = h ^ (1 << (i % HASH_MOD));
    idx = dir * (1 << HASH_MOD) + h;
    return (idx & ~3) | ((idx ^ t) & 3);
  endfunction

  function automatic int m_signed(int v, int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  // Returns {final, flip, sum_dir, main_dir, above} packed in an int
  function automatic int m_eval(int pc, int hist, int mc);
    int m = m_signed(mc, MW);
    int mdir = (m >= 0) ? 1 : 0;
    int s = 8 * (2 * m + 1);
    int sdir, mag, abv, flp, fin;
    for (int t = 0; t < NT; t++) s += 2 * m_tab[m_addr(t, pc, hist, mdir)] + 1;
    sdir = (s >= 0) ? 1 : 0;
    mag  = (s < 0) ? -s : s;
    abv  = (mag > m_thr) ? 1 : 0;
    flp  = (sdir != mdir && abv == 1) ? 1 : 0;
    fin  = flp ? sdir : mdir;
    return fin * 16 + flp * 8 + sdir * 4 + mdir * 2 + abv;
  endfunction

  always @(posedge clk) begin
    if (rst_n && upd_valid) begin
      int r, fin, sdir, mdir, abv, tk;
      int ad [NT];
      int nv [NT];
      r = m_eval(int'(upd_pc), int'(upd_hist), int'(upd_main_ctr));
      fin = (r >> 4) & 1; sdir = (r >> 2) & 1; mdir = (r >> 1) & 1; abv = r & 1;
      tk = upd_taken ? 1 : 0;
      if (fin != tk || abv == 0) begin
        for (int t = 0; t < NT; t++) begin
          ad[t] = m_addr(t, int'(upd_pc), int'(upd_hist), mdir);
          nv[t] = m_tab[ad[t]] + (tk ? 1 : -1);
          if (nv[t] > 31) nv[t] = 31;
          if (nv[t] < -32) nv[t] = -32;
        end
        for (int t = 0; t < NT; t++) m_tab[ad[t]] = nv[t];
      end
      if (sdir != mdir) begin
        if (sdir != tk) begin
          if (m_adp == (1 << (AW - 1)) - 1) begin
            m_adp = 0;
            if (m_thr < (1 << TW) - 1) m_thr++;
          end else m_adp++;
        end else begin
          if (m_adp == -(1 << (AW - 1))) begin
            m_adp = 0;
            if (m_thr > 0) m_thr--;
          end else m_adp--;
        end
      end
    end
  end

  // Compare on the falling edge, inputs settled since the previous one
  always @(negedge clk) begin
    if (rst_n) begin
      int r;
      r = m_eval(int'(pred_pc), int'(pred_hist), int'(pred_main_ctr));
      n_checks += 2;
      if (pred_dir !== 1'((r >> 4) & 1)) begin
        n_fails++;
        $display("FAIL %s pred_dir actual=%0b expected=%0b t=%0t", tag, pred_dir, (r >> 4) & 1, $time);
      end
      if (pred_flip !== 1'((r >> 3) & 1)) begin
        n_fails++;
        $display("FAIL %s pred_flip actual=%0b expected=%0b t=%0t", tag, pred_flip, (r >> 3) & 1, $time);
      end
    end
  end

  task automatic step(int pc, int hist, int mc, bit uv, bit tk);
    @(negedge clk); #1;
    pred_pc = PCW'(pc); pred_hist = HW'(hist); pred_main_ctr = MW'(mc);
    upd_pc  = PCW'(pc); upd_hist  = HW'(hist); upd_main_ctr  = MW'(mc);
    upd_valid = uv; upd_taken = tk;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_tab[i] = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R2 R3: reset state seen through predictions, no updates
    tag = "R2 R3";
    for (int i = 0; i < 20; i++) step($urandom, $urandom, $urandom, 1'b0, 1'b0);

    // R5 R4 R9: one branch trained taken while the main predictor leans not taken
    tag = "R5 R4 R9";
    for (int i = 0; i < 60; i++) step(16'h1234, 17'h0F0F1, 7, 1'b1, 1'b1);

    // R6 R7: correction attempts, right then wrong, across many branches
    tag = "R6 R7";
    for (int k = 0; k < 60; k++) begin
      for (int i = 0; i < 10; i++) step(k * 37 + 5, k * 91, 7, 1'b1, 1'b1);
      for (int i = 0; i < 14; i++) step(k * 37 + 5, k * 91, 7, 1'b1, 1'b0);
    end
    for (int k = 0; k < 40; k++)
      for (int i = 0; i < 20; i++) step(k * 53 + 9, k * 13, 7, 1'b1, 1'b1);

    // R8: no updates, the trained branch must still predict as before
    tag = "R8";
    for (int i = 0; i < 40; i++) begin
      step($urandom, $urandom, $urandom, 1'b0, 1'(i));
      step(16'h1234, 17'h0F0F1, 7, 1'b0, 1'b0);
    end

    // R1 R3 R4 R5 R6 R9: mixed traffic with separate predict and update streams
    tag = "R1 R3 R4 R5 R6 R9";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      pred_pc = PCW'($urandom % 8); pred_hist = HW'($urandom % 4 == 0 ? 0 : $urandom);
      pred_main_ctr = MW'($urandom);
      upd_pc = PCW'($urandom % 8); upd_hist = HW'($urandom % 4 == 0 ? 0 : $urandom);
      upd_main_ctr = MW'($urandom % 2 ? 7 : $urandom);
      upd_valid = ($urandom % 4) != 0; upd_taken = ($urandom % 3) != 0;
    end
    step(0, 0, 0, 1'b0, 1'b0);
    @(negedge clk); #1;
    summary();
  end

endmodule